// File: doc/BRIEF.md
# Exception Vector Dispatch Unit

This unit sits next to a simple in-order core and turns exception events into a control-flow redirect. Software fills a 256-entry table of handler start addresses through a small write port during boot. When the execute stage reports a synchronous event (divide error, protection fault, page fault, machine check or a software trap carrying an 8-bit vector), or an external interrupt arrives between instructions, the unit picks one event. It looks up the handler address for that vector and, one cycle later, pulses a redirect strobe. With the strobe it gives the fetch address, the return address to save and a 2-bit class code.

The class decides the return address. A fault returns to the instruction that raised it, so that instruction runs again. A trap or an interrupt returns to the following instruction. An abort never returns: the unit raises a terminate flag and gives a zero return address. Vectors below 32 are reserved for the core and have fixed classes. For vectors 32 to 255, a class table that software can write gives the class.

Top module: `exc_dispatch`

## Requirements
- R1: While reset is asserted, and in the first cycles after release, `redir_valid_o` and `terminate_o` are low.
- R2: An accepted event in cycle N gives `redir_valid_o` high for exactly cycle N+1. A cycle with no accepted event gives no strobe in the cycle after it.
- R3: `redir_addr_o` equals the handler table entry of the chosen vector. An entry that was never written since reset reads as zero. A handler write uses `cfg_sel_i`=0, index `cfg_idx_i` and data `cfg_wdata_i`.
- R4: When a table write and a lookup of the same entry fall in the same cycle, the redirect uses the contents from before that write. This holds for both the handler table and the class table.
- R5: Divide error selects vector 0, protection fault vector 13, page fault vector 14, all of class fault. Machine check selects vector 18, of class abort. Any other vector below 32 has class fault.
- R6: The class code is 00 fault, 01 trap, 10 interrupt, 11 abort. For vectors 32 to 255 the class comes from the class table, which resets to 01, so a trap to vector 128 is a trap. A class write uses `cfg_sel_i`=1 with the code in `cfg_wdata_i[1:0]`. A class write to a vector below 32 has no effect.
- R7: For a fault, `ret_addr_o` is the `pc_cur_i` of the event cycle. For a trap or an interrupt, it is the `pc_next_i` of the event cycle.
- R8: For an abort, `terminate_o` pulses together with the redirect and `ret_addr_o` is zero. For every other class, `terminate_o` stays low.
- R9: Among synchronous requests in the same cycle, the one with the lowest vector number wins. This includes the software trap vector.
- R10: Any synchronous request beats an interrupt in the same cycle. The interrupt is not taken in that cycle.
- R11: An interrupt request is accepted only in a cycle with `instr_done_i` high. Without it, no redirect comes from the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Table write enable |
| cfg_sel_i | input | 1 | 0 writes the handler address, 1 writes the class code |
| cfg_idx_i | input | 8 | Vector written |
| cfg_wdata_i | input | 32 | Write data (class uses bits 1:0) |
| div_err_i | input | 1 | Divide by zero in the current instruction |
| prot_flt_i | input | 1 | Protection fault in the current instruction |
| page_flt_i | input | 1 | Page fault in the current instruction |
| mchk_i | input | 1 | Machine check |
| swt_req_i | input | 1 | Software trap instruction |
| swt_vec_i | input | 8 | Trap vector carried by the instruction |
| irq_req_i | input | 1 | External interrupt request (level) |
| irq_vec_i | input | 8 | Interrupt vector |
| instr_done_i | input | 1 | Current instruction completes this cycle |
| pc_cur_i | input | 32 | Address of the current instruction |
| pc_next_i | input | 32 | Address of the following instruction |
| redir_valid_o | output | 1 | One-cycle redirect strobe |
| redir_addr_o | output | 32 | Handler fetch address |
| ret_addr_o | output | 32 | Return address to save |
| exc_class_o | output | 2 | Class code of the taken event |
| terminate_o | output | 1 | Abort: the program must be terminated |

## Verification
The hardest case to reach is a cycle where several things collide. A table write can hit the same entry that is being looked up, while synchronous requests compete with each other and with a pending interrupt. Some entries are also left unwritten. Directed steps set up each collision on purpose, with distinct handler addresses so the chosen vector shows at the address port. The random phase writes often to a small window of vectors that the events also use, so same-entry write-and-lookup cycles and class changes keep happening among mixed requests.

// File: rtl/excd_pkg.sv
package excd_pkg;
  localparam logic [1:0] CLS_FAULT = 2'b00;
  localparam logic [1:0] CLS_TRAP  = 2'b01;
  localparam logic [1:0] CLS_INTR  = 2'b10;
  localparam logic [1:0] CLS_ABORT = 2'b11;

  localparam int unsigned HW_RESERVED = 32;
  localparam int unsigned NUM_FIXED   = 4;
  localparam int unsigned VEC_MCHK    = 18;

  // vector of fixed-source request i, ascending so lower index = higher priority
  function automatic int unsigned fixed_vec(input int unsigned i);
    case (i)
      0:       return 0;
      1:       return 13;
      2:       return 14;
      default: return VEC_MCHK;
    endcase
  endfunction

  function automatic logic [1:0] hw_class(input int unsigned v);
    return (v == VEC_MCHK) ? CLS_ABORT : CLS_FAULT;
  endfunction
endpackage

// File: rtl/excd_arbiter.sv
module excd_arbiter #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             div_err_i,
  input  logic             prot_flt_i,
  input  logic             page_flt_i,
  input  logic             mchk_i,
  input  logic             swt_req_i,
  input  logic [VEC_W-1:0] swt_vec_i,
  input  logic             irq_req_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  input  logic             instr_done_i,
  output logic             take_o,
  output logic             is_irq_o,
  output logic             sync_any_o,
  output logic [VEC_W-1:0] vec_o
);
  import excd_pkg::*;

  logic [NUM_FIXED-1:0] fix_req;
  logic [VEC_W-1:0]     fix_vec [NUM_FIXED];
  logic                 fix_hit;
  logic [VEC_W-1:0]     fix_best;
  logic                 swt_wins;

  assign fix_req = {mchk_i, page_flt_i, prot_flt_i, div_err_i};

  for (genvar i = 0; i < NUM_FIXED; i++) begin : g_fix
    assign fix_vec[i] = VEC_W'(fixed_vec(i));
  end

  always_comb begin
    fix_hit  = 1'b0;
    fix_best = '0;
    for (int i = NUM_FIXED - 1; i >= 0; i--) begin
      if (fix_req[i]) begin
        fix_hit  = 1'b1;
        fix_best = fix_vec[i];
      end
    end
  end

  assign swt_wins   = swt_req_i && (!fix_hit || (swt_vec_i < fix_best));
  assign sync_any_o = fix_hit || swt_req_i;

  always_comb begin
    take_o   = 1'b0;
    is_irq_o = 1'b0;
    vec_o    = '0;
    if (swt_wins) begin
      take_o = 1'b1;
      vec_o  = swt_vec_i;
    end else if (fix_hit) begin
      take_o = 1'b1;
      vec_o  = fix_best;
    end else if (irq_req_i && instr_done_i) begin
      take_o   = 1'b1;
      is_irq_o = 1'b1;
      vec_o    = irq_vec_i;
    end
  end
endmodule

// File: rtl/excd_handler_table.sv
module excd_handler_table #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [VEC_W-1:0]  widx_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [VEC_W-1:0]  ridx_i,
  output logic [ADDR_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << VEC_W;

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  written_q;
  logic [DEPTH-1:0]  written_d;

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  always_comb begin
    written_d = written_q;
    if (we_i) begin
      written_d[widx_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      written_q <= '0;
    end else begin
      written_q <= written_d;
    end
  end

  // read sees state before this cycle's write
  assign rdata_o = written_q[ridx_i] ? mem_q[ridx_i] : '0;
endmodule

// File: rtl/excd_class_table.sv
module excd_class_table #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [VEC_W-1:0] widx_i,
  input  logic [1:0]       wdata_i,
  input  logic [VEC_W-1:0] ridx_i,
  output logic [1:0]       rdata_o
);
  import excd_pkg::*;
  localparam int unsigned DEPTH = 1 << VEC_W;

  logic [1:0] cls_arr [DEPTH];

  for (genvar v = 0; v < DEPTH; v++) begin : g_vec
    if (v < HW_RESERVED) begin : g_hw
      assign cls_arr[v] = hw_class(v);
    end else begin : g_sw
      logic       en;
      logic [1:0] q;
      assign en = we_i && (widx_i == VEC_W'(v));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= CLS_TRAP;
        end else if (en) begin
          q <= wdata_i;
        end
      end
      assign cls_arr[v] = q;
    end
  end

  assign rdata_o = cls_arr[ridx_i];
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [VEC_W-1:0]  cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              div_err_i,
  input  logic              prot_flt_i,
  input  logic              page_flt_i,
  input  logic              mchk_i,
  input  logic              swt_req_i,
  input  logic [VEC_W-1:0]  swt_vec_i,
  input  logic              irq_req_i,
  input  logic [VEC_W-1:0]  irq_vec_i,
  input  logic              instr_done_i,
  input  logic [ADDR_W-1:0] pc_cur_i,
  input  logic [ADDR_W-1:0] pc_next_i,
  output logic              redir_valid_o,
  output logic [ADDR_W-1:0] redir_addr_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic [1:0]        exc_class_o,
  output logic              terminate_o
);
  import excd_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  logic             take, is_irq, sync_any;
  logic [VEC_W-1:0] sel_vec;
  logic [ADDR_W-1:0] hdl_addr;
  logic [1:0]       sel_cls;
  logic             hdl_we, cls_we;

  assign hdl_we = cfg_we_i && !cfg_sel_i;
  assign cls_we = cfg_we_i &&  cfg_sel_i;

  excd_arbiter #(.VEC_W(VEC_W)) u_arb (
    .div_err_i    (div_err_i),
    .prot_flt_i   (prot_flt_i),
    .page_flt_i   (page_flt_i),
    .mchk_i       (mchk_i),
    .swt_req_i    (swt_req_i),
    .swt_vec_i    (swt_vec_i),
    .irq_req_i    (irq_req_i),
    .irq_vec_i    (irq_vec_i),
    .instr_done_i (instr_done_i),
    .take_o       (take),
    .is_irq_o     (is_irq),
    .sync_any_o   (sync_any),
    .vec_o        (sel_vec)
  );

  excd_handler_table #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_hdl (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .we_i    (hdl_we),
    .widx_i  (cfg_idx_i),
    .wdata_i (cfg_wdata_i),
    .ridx_i  (sel_vec),
    .rdata_o (hdl_addr)
  );

  excd_class_table #(.VEC_W(VEC_W)) u_cls (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .we_i    (cls_we),
    .widx_i  (cfg_idx_i),
    .wdata_i (cfg_wdata_i[1:0]),
    .ridx_i  (sel_vec),
    .rdata_o (sel_cls)
  );

  // next state
  logic [ADDR_W-1:0] ret_d;
  logic              term_d;

  always_comb begin
    term_d = 1'b0;
    case (sel_cls)
      CLS_FAULT: ret_d = pc_cur_i;
      CLS_ABORT: begin
        ret_d  = '0;
        term_d = take;
      end
      default:   ret_d = pc_next_i;
    endcase
  end

  // registers
  logic              valid_q, term_q;
  logic [ADDR_W-1:0] addr_q, ret_q;
  logic [1:0]        cls_q;

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
      term_q  <= 1'b0;
    end else begin
      valid_q <= take;
      term_q  <= term_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (take) begin
      addr_q <= hdl_addr;
      ret_q  <= ret_d;
      cls_q  <= sel_cls;
    end
  end

  assign redir_valid_o = valid_q;
  assign redir_addr_o  = addr_q;
  assign ret_addr_o    = ret_q;
  assign exc_class_o   = cls_q;
  assign terminate_o   = term_q;

  // checks
  a_r2_strobe_has_cause: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    redir_valid_o |-> $past(div_err_i || prot_flt_i || page_flt_i || mchk_i || swt_req_i
                            || (irq_req_i && instr_done_i)));

  a_r7_fault_ret: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (redir_valid_o && exc_class_o == CLS_FAULT) |-> (ret_addr_o == $past(pc_cur_i)));

  a_r7_trap_ret: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (redir_valid_o && (exc_class_o == CLS_TRAP || exc_class_o == CLS_INTR))
      |-> (ret_addr_o == $past(pc_next_i)));

  a_r8_abort_term: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    terminate_o |-> (redir_valid_o && exc_class_o == CLS_ABORT && ret_addr_o == '0));

  a_r10_sync_first: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    sync_any |-> (take && !is_irq));

  a_r11_irq_on_done: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (take && is_irq) |-> instr_done_i);

  a_r5_mchk_vec: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (mchk_i && !div_err_i && !prot_flt_i && !page_flt_i && !(swt_req_i && swt_vec_i < VEC_W'(VEC_MCHK)))
      |-> (sel_vec == VEC_W'(VEC_MCHK)));
endmodule

// File: tb/exc_dispatch_test.sv
`timescale 1ns/1ps
module exc_dispatch_test;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          cfg_we, cfg_sel;
  logic [7:0]    cfg_idx;
  logic [AW-1:0] cfg_wdata;
  logic          div_err, prot_flt, page_flt, mchk, swt_req, irq_req, instr_done;
  logic [7:0]    swt_vec, irq_vec;
  logic [AW-1:0] pc_cur, pc_next;
  logic          redir_valid, terminate;
  logic [AW-1:0] redir_addr, ret_addr;
  logic [1:0]    exc_class;

  exc_dispatch uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .div_err_i(div_err), .prot_flt_i(prot_flt), .page_flt_i(page_flt), .mchk_i(mchk),
    .swt_req_i(swt_req), .swt_vec_i(swt_vec), .irq_req_i(irq_req), .irq_vec_i(irq_vec),
    .instr_done_i(instr_done), .pc_cur_i(pc_cur), .pc_next_i(pc_next),
    .redir_valid_o(redir_valid), .redir_addr_o(redir_addr), .ret_addr_o(ret_addr),
    .exc_class_o(exc_class), .terminate_o(terminate)
  );

  // bench model of software-visible table state
  logic [AW-1:0] m_addr [256];
  bit            m_wr   [256];
  logic [1:0]    m_cls  [256];

  int total = 0, bad = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] cls_of(input int v);
    if (v < 32) return (v == 18) ? 2'b11 : 2'b00;
    return m_cls[v];
  endfunction

  task automatic idle();
    cfg_we = 0; cfg_sel = 0; cfg_idx = 0; cfg_wdata = 0;
    div_err = 0; prot_flt = 0; page_flt = 0; mchk = 0;
    swt_req = 0; swt_vec = 0; irq_req = 0; irq_vec = 0; instr_done = 0;
  endtask

  // inputs already driven; run one cycle and compare
  task automatic step(input string tag);
    bit e_take = 0; int e_vec = 256; logic [1:0] e_cls; logic [AW-1:0] e_ret, e_addr;
    if (div_err) e_vec = 0;
    else if (prot_flt) e_vec = 13;
    else if (page_flt) e_vec = 14;
    else if (mchk) e_vec = 18;
    if (swt_req && int'(swt_vec) < e_vec) e_vec = int'(swt_vec);
    if (e_vec < 256) e_take = 1;
    else if (irq_req && instr_done) begin e_take = 1; e_vec = int'(irq_vec); end
    if (e_take) begin
      e_cls  = cls_of(e_vec);
      e_addr = m_wr[e_vec] ? m_addr[e_vec] : '0;
      e_ret  = (e_cls == 2'b00) ? pc_cur : (e_cls == 2'b11) ? '0 : pc_next;
    end
    @(posedge clk); #1;
    chk({tag, " R2 strobe"}, 64'(redir_valid), 64'(e_take));
    if (e_take) begin
      chk({tag, " R3 addr"}, 64'(redir_addr), 64'(e_addr));
      chk({tag, " R6 class"}, 64'(exc_class), 64'(e_cls));
      chk({tag, " R7 ret"}, 64'(ret_addr), 64'(e_ret));
      chk({tag, " R8 term"}, 64'(terminate), 64'(e_cls == 2'b11));
    end else begin
      chk({tag, " R8 term idle"}, 64'(terminate), 64'd0);
    end
    if (cfg_we) begin
      if (!cfg_sel) begin m_addr[cfg_idx] = cfg_wdata; m_wr[cfg_idx] = 1; end
      else if (cfg_idx >= 32) m_cls[cfg_idx] = cfg_wdata[1:0];
    end
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input bit sel, input int idx, input logic [AW-1:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_idx = 8'(idx); cfg_wdata = d;
    step("cfg");
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    if (!done_flag) $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    for (int i = 0; i < 256; i++) begin m_wr[i] = 0; m_addr[i] = 0; m_cls[i] = 2'b01; end
    idle(); pc_cur = 32'h0800_c040; pc_next = 32'h0800_c050;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 strobe in reset", 64'(redir_valid), 0);
    chk("R1 term in reset", 64'(terminate), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 strobe after reset", 64'(redir_valid), 0);

    // R3: unwritten entry reads zero
    div_err = 1; step("R3 unwritten");

    // handlers for most vectors, some left blank
    for (int v = 0; v < 256; v++)
      if (v % 7 != 3) wr(0, v, 32'hC000_0000 | (v << 4));

    // R5: each fixed source alone
    div_err = 1; step("R5 div");
    prot_flt = 1; step("R5 prot");
    page_flt = 1; step("R5 page");
    mchk = 1; step("R5 R8 mchk abort");
    swt_req = 1; swt_vec = 8'd5; step("R5 low trap vector fault");
    // R6: trap 0x80 is a trap by default
    swt_req = 1; swt_vec = 8'h80; pc_next = 32'h0804_d084; step("R6 trap 128");
    // R6: class write below 32 ignored
    wr(1, 13, 32'h3); prot_flt = 1; step("R6 ignored class write");
    wr(1, 200, 32'h2); irq_req = 1; irq_vec = 8'd200; instr_done = 1; step("R6 R7 interrupt");
    // R11: interrupt without completion
    irq_req = 1; irq_vec = 8'd200; instr_done = 0; step("R11 no done");
    // R9: lowest vector wins
    page_flt = 1; mchk = 1; swt_req = 1; swt_vec = 8'd40; step("R9 page over mchk");
    prot_flt = 1; swt_req = 1; swt_vec = 8'd7; step("R9 trap 7 wins");
    // R10: sync beats interrupt
    mchk = 1; irq_req = 1; irq_vec = 8'd33; instr_done = 1; step("R10 sync first");
    // R4: same-cycle write and lookup
    swt_req = 1; swt_vec = 8'd64; cfg_we = 1; cfg_sel = 0; cfg_idx = 8'd64; cfg_wdata = 32'hDEAD_0000;
    step("R4 handler old");
    swt_req = 1; swt_vec = 8'd64; step("R4 handler new");
    swt_req = 1; swt_vec = 8'd64; cfg_we = 1; cfg_sel = 1; cfg_idx = 8'd64; cfg_wdata = 32'h3;
    step("R4 class old");
    swt_req = 1; swt_vec = 8'd64; step("R4 R8 class new abort");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      pc_cur  = $urandom; pc_next = pc_cur + 4;
      if ($urandom_range(0, 3) == 0) begin
        cfg_we = 1; cfg_sel = $urandom_range(0, 1);
        cfg_idx = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(24, 40));
        cfg_wdata = $urandom;
      end
      div_err  = ($urandom_range(0, 9) == 0);
      prot_flt = ($urandom_range(0, 9) == 0);
      page_flt = ($urandom_range(0, 9) == 0);
      mchk     = ($urandom_range(0, 15) == 0);
      swt_req  = ($urandom_range(0, 5) == 0);
      swt_vec  = ($urandom_range(0, 1) == 0) ? 8'($urandom) : 8'($urandom_range(24, 40));
      irq_req  = ($urandom_range(0, 2) == 0);
      irq_vec  = 8'($urandom_range(24, 40));
      instr_done = ($urandom_range(0, 1) == 0);
      step("rand");
    end

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule